// File: doc/BRIEF.md
# Three-Phase Switching Pattern Sequencer

The sequencer plays back stored switching words for the three phases of a multilevel inverter bridge. All three phases read one pattern table. A programmable divider turns the fixed system clock into a step rate, and that rate sets the output fundamental frequency. A single step position counter advances once per step. Each phase adds its own angular offset to that count, so phase A, B and C walk the same table shifted in angle.

The table stores only the first half of the fundamental cycle. In the second half, the word that was read is mirrored by exchanging each complementary switch pair. Each phase has its own capacitor-balance status bit, which forms the top table address bit and so chooses one of two stored pattern sets.

The three phases read the single table port one after another at the start of each step period. The fetched words wait in a staging buffer. All three output words are then loaded together on the step boundary.

Top module: `tri_phase_pat_seq`

## Requirements
- R1: While reset is asserted, and until the first step boundary after reset, all three output words are zero and the step position is zero.
- R2: The table word at 10-bit address a is ((a << 2) XOR a), truncated to 12 bits. A phase fetches from address {status bit of that phase, position[8:0]}.
- R3: With a divider value D of at least 5, the outputs update exactly once every D clock cycles. The first update comes on the D-th rising edge after reset is released.
- R4: Nonzero divider values from 1 to 4 run exactly like a value of 5.
- R5: A divider value of zero freezes the step position and all outputs. When a nonzero value returns, the sequence resumes from the frozen position.
- R6: In a step, phase A uses position n, phase B uses n + offset_b, and phase C uses n + offset_c, all modulo 1024. n increments by one per step and wraps from 1023 to 0.
- R7: When a phase position is 512 or above, the fetched word has bits 2k and 2k+1 exchanged for every k from 0 to 5. Below 512 it is passed unchanged.
- R8: The status bit and offset of phase A, B and C are sampled in the first, second and third clock cycle of the step period, in that order. Only those cycles read the table.
- R9: The three outputs change only on a step boundary, and all three change on the same clock edge. The words loaded at a boundary are the ones fetched during the step period that the boundary ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Clock cycles per step (0 holds) |
| ofs_b | input | 10 | Phase B position offset in steps |
| ofs_c | input | 10 | Phase C position offset in steps |
| cap_hi | input | 3 | Per-phase capacitor status, bit 0 = A, bit 2 = C |
| pat_a | output | 12 | Phase A switching word |
| pat_b | output | 12 | Phase B switching word |
| pat_c | output | 12 | Phase C switching word |

## Verification
The first pattern uses the usual offsets (341 and 683) over a long run at the shortest period. This shows the position wrap at 1024, and it places phase C in the mirrored half from the start. The second pattern sets all offsets to zero and applies each status value in turn. All three phases must then give identical words, which separates the table content and the set select from the offset adder. The status bits are also changed at random cycles inside a step period; this shows whether each phase samples its bit in its own read slot and not at the boundary. Finally, divider values of 0 through 4 and random mixes of offset, status and period separate the hold, the minimum-period clamp, and the alignment of the three outputs.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int WORD_W  = 12;
  localparam int DEPTH   = 1024;
  localparam int AW      = $clog2(DEPTH);
  localparam int IDX_W   = AW - 1;
  localparam int POS_W   = AW;
  localparam int NPH     = 3;
  localparam int PH_W    = 2;
  localparam int MIN_DIV = NPH + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [AW-1:0]     taddr_t;

  // stored content of one table entry
  function automatic word_t table_word(taddr_t a);
    word_t w;
    w = word_t'(a) << 2;
    return w ^ word_t'(a);
  endfunction

  // exchange each complementary switch pair
  function automatic word_t swap_pairs(word_t w);
    word_t r;
    for (int k = 0; k < WORD_W / 2; k++) begin
      r[2*k]   = w[2*k+1];
      r[2*k+1] = w[2*k];
    end
    return r;
  endfunction

  function automatic taddr_t table_addr(logic set_sel, pos_t pos);
    return {set_sel, pos[IDX_W-1:0]};
  endfunction

  function automatic logic second_half(pos_t pos);
    return pos[POS_W-1];
  endfunction
endpackage

// File: rtl/tps_step_div.sv
module tps_step_div import tps_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic [DIV_W-1:0] pre_cnt,
  output logic             step_tick,
  output logic             rd_en,
  output logic [PH_W-1:0]  rd_ph
);
  logic             run;
  logic [DIV_W-1:0] eff_div;

  assign run     = (div_val != '0);
  assign eff_div = (div_val < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_val;

  assign step_tick = run && (pre_cnt >= eff_div - 1'b1);
  assign rd_en     = run && (pre_cnt < DIV_W'(NPH));
  assign rd_ph     = pre_cnt[PH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_cnt <= '0;
    else if (!run)       pre_cnt <= '0;
    else if (step_tick)  pre_cnt <= '0;
    else                 pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/tps_addr_gen.sv
module tps_addr_gen import tps_pkg::*; (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_tick,
  input  logic [NPH-1:0][POS_W-1:0]  ofs,
  output pos_t                       step_pos,
  output logic [NPH-1:0][POS_W-1:0]  ph_pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         step_pos <= '0;
    else if (step_tick) step_pos <= step_pos + 1'b1;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    assign ph_pos[g] = step_pos + ofs[g];
  end
endmodule

// File: rtl/tps_pat_table.sv
module tps_pat_table import tps_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_en,
  input  taddr_t rd_addr,
  output word_t  rd_data
);
  word_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = table_word(taddr_t'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tri_phase_pat_seq.sv
module tri_phase_pat_seq import tps_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [POS_W-1:0]  ofs_b,
  input  logic [POS_W-1:0]  ofs_c,
  input  logic [NPH-1:0]    cap_hi,
  output logic [WORD_W-1:0] pat_a,
  output logic [WORD_W-1:0] pat_b,
  output logic [WORD_W-1:0] pat_c
);
  logic [DIV_W-1:0]           pre_cnt;
  logic                       step_tick;
  logic                       rd_en;
  logic [PH_W-1:0]            rd_ph;
  pos_t                       step_pos;
  logic [NPH-1:0][POS_W-1:0]  ofs_all;
  logic [NPH-1:0][POS_W-1:0]  ph_pos;
  pos_t                       sel_pos;
  logic                       sel_cap;
  taddr_t                     rd_addr;
  word_t                      rd_data;
  logic                       rd_vld_q;
  logic [PH_W-1:0]            rd_ph_q;
  logic                       half_q;
  word_t                      fetch_word;
  logic [NPH-1:0][WORD_W-1:0] stage_q;
  logic [NPH-1:0][WORD_W-1:0] out_q;

  assign ofs_all = {ofs_c, ofs_b, {POS_W{1'b0}}};

  tps_step_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .pre_cnt(pre_cnt),
    .step_tick(step_tick), .rd_en(rd_en), .rd_ph(rd_ph)
  );

  tps_addr_gen u_agen (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .ofs(ofs_all),
    .step_pos(step_pos), .ph_pos(ph_pos)
  );

  // round-robin slot owner picks position and set bit
  always_comb begin
    sel_pos = ph_pos[0];
    sel_cap = cap_hi[0];
    for (int p = 1; p < NPH; p++) begin
      if (rd_ph == PH_W'(p)) begin
        sel_pos = ph_pos[p];
        sel_cap = cap_hi[p];
      end
    end
  end

  assign rd_addr = table_addr(sel_cap, sel_pos);

  tps_pat_table u_tab (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      rd_ph_q  <= '0;
      half_q   <= 1'b0;
    end else begin
      rd_vld_q <= rd_en;
      rd_ph_q  <= rd_ph;
      half_q   <= second_half(sel_pos);
    end
  end

  assign fetch_word = half_q ? swap_pairs(rd_data) : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      for (int p = 0; p < NPH; p++) begin
        if (rd_vld_q && rd_ph_q == PH_W'(p)) stage_q[p] <= fetch_word;
      end
      if (step_tick) out_q <= stage_q;
    end
  end

  assign pat_a = out_q[0];
  assign pat_b = out_q[1];
  assign pat_c = out_q[2];
endmodule

// File: rtl/tps_seq_chk.sv
module tps_seq_chk import tps_pkg::*; #(
  parameter int DIV_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  div_val,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic              step_tick,
  input logic              rd_en,
  input logic [PH_W-1:0]   rd_ph,
  input pos_t              step_pos,
  input logic [WORD_W-1:0] pat_a,
  input logic [WORD_W-1:0] pat_b,
  input logic [WORD_W-1:0] pat_c
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pat_a == '0 && pat_b == '0 && pat_c == '0 && step_pos == '0));

  // R4
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |-> pre_cnt >= DIV_W'(MIN_DIV - 1));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> !step_tick);

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |-> (!step_tick && !rd_en));

  // R5
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> $stable(step_pos));

  // R6
  pos_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> step_pos == pos_t'($past(step_pos) + 1'b1));

  // R8
  read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (!rd_en || rd_ph == PH_W'($past(rd_ph) + 1'b1)));

  // R9
  aligned_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> ($stable(pat_a) && $stable(pat_b) && $stable(pat_c)));
endmodule

bind tri_phase_pat_seq tps_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_val(div_val), .pre_cnt(pre_cnt),
  .step_tick(step_tick), .rd_en(rd_en), .rd_ph(rd_ph), .step_pos(step_pos),
  .pat_a(pat_a), .pat_b(pat_b), .pat_c(pat_c)
);

// File: tb/tri_phase_pat_seq_tb.sv
module tri_phase_pat_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_val = 16'd7;
  logic [9:0]  ofs_b = 10'd341;
  logic [9:0]  ofs_c = 10'd683;
  logic [2:0]  cap_hi = 3'b000;
  logic [11:0] pat_a, pat_b, pat_c;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // reference state
  int          mpre = 0;
  int unsigned mbase = 0;
  logic [11:0] exp_stage [3];
  logic [11:0] exp_out [3];

  tri_phase_pat_seq #(.DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .ofs_b(ofs_b), .ofs_c(ofs_c),
    .cap_hi(cap_hi), .pat_a(pat_a), .pat_b(pat_b), .pat_c(pat_c)
  );

  always #10 clk = ~clk;

  function automatic int eff_period(int d);
    if (d == 0) return 0;
    if (d < 5) return 5;
    return d;
  endfunction

  // expected word from requirement text (R2, R6, R7)
  function automatic logic [11:0] ref_word(int ph, int unsigned base, int ob, int oc, logic [2:0] cap);
    int unsigned pos, adr, w;
    int o;
    o   = (ph == 0) ? 0 : ((ph == 1) ? ob : oc);
    pos = (base + o) % 1024;
    adr = (cap[ph] ? 512 : 0) + (pos % 512);
    w   = ((adr * 4) ^ adr) & 32'hFFF;
    if (pos >= 512) w = ((w & 32'hAAA) >> 1) | ((w & 32'h555) << 1);
    return w[11:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mpre = 0;
      mbase = 0;
      for (int p = 0; p < 3; p++) begin
        exp_stage[p] = '0;
        exp_out[p] = '0;
      end
    end else begin
      int e;
      e = eff_period(int'(div_val));
      if (e != 0 && mpre < 3)
        exp_stage[mpre] = ref_word(mpre, mbase, int'(ofs_b), int'(ofs_c), cap_hi);
      if (e != 0 && mpre >= e - 1) begin
        for (int p = 0; p < 3; p++) exp_out[p] = exp_stage[p];
        mbase = (mbase + 1) % 1024;
        mpre = 0;
      end else if (e != 0) begin
        mpre = mpre + 1;
      end else begin
        mpre = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_run++;
      if (pat_a !== exp_out[0] || pat_b !== exp_out[1] || pat_c !== exp_out[2]) begin
        n_fail++;
        $display("FAIL %s: outputs %h %h %h expected %h %h %h", cur_tag,
                 pat_a, pat_b, pat_c, exp_out[0], exp_out[1], exp_out[2]);
      end
    end
  end

  task automatic run_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: cycles %0d expected fewer", 190000);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    // R1: held in reset, outputs all zero
    cur_tag = "R1";
    run_cycles(4);
    rst_n = 1'b1;
    // R3: period of 7, first update on the 7th edge
    cur_tag = "R3";
    run_cycles(7 * 30);
    // R7: phase C starts in the mirrored half
    cur_tag = "R7";
    run_cycles(7 * 20);
    // R6: long run through the 1023 -> 0 wrap
    cur_tag = "R6";
    div_val = 16'd5;
    run_cycles(5 * 1100);
    // R5: hold, then resume
    cur_tag = "R5";
    div_val = 16'd0;
    run_cycles(60);
    div_val = 16'd6;
    run_cycles(6 * 10);
    // R4: small nonzero values clamp to five
    cur_tag = "R4";
    for (int d = 1; d <= 4; d++) begin
      div_val = 16'(d);
      run_cycles(5 * 15);
    end
    // R8: status changes at arbitrary cycles within a step
    cur_tag = "R8";
    div_val = 16'd8;
    for (int i = 0; i < 200; i++) begin
      cap_hi = 3'($urandom);
      run_cycles(1 + int'($urandom % 8));
    end
    // R2: zero offsets, each set
    cur_tag = "R2";
    ofs_b = '0;
    ofs_c = '0;
    div_val = 16'd5;
    for (int s = 0; s < 8; s++) begin
      cap_hi = 3'(s);
      run_cycles(5 * 12);
    end
    // R9: random mixes of period, offset and status
    cur_tag = "R9";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 10);
      div_val = (r == 0) ? 16'd0 : 16'(r + 2);
      ofs_b = 10'($urandom);
      ofs_c = 10'($urandom);
      cap_hi = 3'($urandom);
      run_cycles(1 + int'($urandom % 20));
    end
    // R1: reset again mid-run
    cur_tag = "R1";
    rst_n = 1'b0;
    run_cycles(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule